// File: doc/BRIEF.md
# Speculative Branch Path History Queue

This block keeps an ordered record of indirect branches from the moment they are predicted until they leave the committed window. Each record holds the branch address, its predicted target and an instruction sequence number. New records go in at the young end. A squash cuts away every record younger than a given sequence number. After resolution, the target of the youngest surviving record can be patched. The newest targets are read out continuously, newest first, so that a predictor can fold them into its table index.

Commit is held back by a head pointer. That pointer counts how many committed records are kept as path context. While the pointer is below the configured path length, a qualifying commit only moves the pointer forward. Once the pointer has reached the path length, a qualifying commit drops the oldest record instead. Storage is a circular buffer with an occupancy count. A record that arrives while the buffer is full is refused.

Within one cycle the operations apply in a fixed order: squash, then commit, then target fix, then record. Each operation sees the queue as the operations before it left it. The refusal of a record depends only on the full flag at the start of the cycle.

Top module: `phq_path_queue`

## Requirements
- R1: A record with `rec_valid_i` high while `full_o` is low appends (address, target, sequence) at the young end. `count_o` rises by one, and the new target appears on `hist_tgt_o` slot 0 in the next cycle.
- R2: `full_o` is high exactly when `count_o` equals DEPTH. A record presented while `full_o` is high is dropped, and count, head pointer and read-out stay unchanged.
- R3: A commit while the queue is empty changes neither `count_o` nor `hptr_o`.
- R4: A commit acts only when `hptr_o` is below the entry count and the entry at position `hptr_o` (0 = oldest) has a sequence number less than or equal to `cmt_seq_i` (unsigned compare). Otherwise it has no effect.
- R5: When a commit acts and `hptr_o` is at or above PATH_LEN, the oldest entry is removed and `hptr_o` is unchanged. When a commit acts and `hptr_o` is below PATH_LEN, `hptr_o` rises by one and no entry is removed. `hptr_o` never exceeds PATH_LEN.
- R6: A squash finds the first entry, scanning from oldest to newest, whose sequence number is greater than `sq_seq_i`. It removes that entry and all younger entries, and leaves `hptr_o` unchanged. `oldest_pc_o` and `oldest_seq_o` show the oldest entry whenever the count is non-zero.
- R7: A fix overwrites the target of the youngest entry with `fix_tgt_i`. A fix on an empty queue has no effect.
- R8: Slot p of `hist_tgt_o` (bits p*ADDR_W upward) holds the target of the p-th newest entry, and `hist_vld_o[p]` is high exactly when p is less than the count. Invalid slots read zero.
- R9: Operations in the same cycle apply in this order: squash, commit, fix, record. Each operation acts on the result of the one before it.
- R10: While `rst_ni` is low, `count_o`, `hptr_o`, `full_o` and `hist_vld_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rec_valid_i | input | 1 | Record a predicted indirect branch |
| rec_pc_i | input | ADDR_W | Branch address of the record |
| rec_tgt_i | input | ADDR_W | Predicted target of the record |
| rec_seq_i | input | SEQ_W | Sequence number of the record |
| cmt_valid_i | input | 1 | Commit request |
| cmt_seq_i | input | SEQ_W | Committed sequence number |
| sq_valid_i | input | 1 | Squash request |
| sq_seq_i | input | SEQ_W | Entries with larger sequence number are squashed |
| fix_valid_i | input | 1 | Overwrite the youngest entry's target |
| fix_tgt_i | input | ADDR_W | Resolved target |
| count_o | output | CNT_W | Number of entries held |
| full_o | output | 1 | Buffer full, records refused |
| hptr_o | output | HP_W | Committed-window head pointer |
| oldest_pc_o | output | ADDR_W | Branch address of the oldest entry |
| oldest_seq_o | output | SEQ_W | Sequence number of the oldest entry |
| hist_tgt_o | output | PATH_LEN*ADDR_W | Newest targets, slot 0 newest |
| hist_vld_o | output | PATH_LEN | Slot valid flags |

## Verification
The bench builds the queue with DEPTH 4, PATH_LEN 2 and 8-bit address and sequence fields. The small depth makes the full condition and the wrap of the physical pointers occur every few cycles. A path length of half the depth lets the head pointer saturate while entries remain, so commits that pop and commits that advance both occur often. The 8-bit sequence numbers keep squash and commit thresholds landing inside the held range, which reaches partial squashes, commits blocked by sequence number, and commits blocked by a head pointer left beyond the count after a squash. Directed cycles set up each ordering case, and a long pseudo-random run of mixed operations is compared cycle by cycle against an arithmetic model of the queue.

// File: rtl/phq_pkg.sv
package phq_pkg;

  typedef enum logic [1:0] {
    CMT_HOLD = 2'd0,
    CMT_ADV  = 2'd1,
    CMT_POP  = 2'd2
  } cmt_act_e;

endpackage

// File: rtl/phq_squash_scan.sv
// Finds how many oldest entries survive a squash.
module phq_squash_scan #(
  parameter  int DEPTH = 16,
  parameter  int SEQ_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [PTR_W-1:0]            head_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_i,
  input  logic                        sq_valid_i,
  input  logic [SEQ_W-1:0]            sq_seq_i,
  output logic [CNT_W-1:0]            keep_o
);

  logic             hit;
  logic [PTR_W-1:0] idx;

  always_comb begin
    keep_o = cnt_i;
    hit    = 1'b0;
    idx    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head_i + PTR_W'(i);
      if (sq_valid_i && !hit && (CNT_W'(i) < cnt_i) && (seq_i[idx] > sq_seq_i)) begin
        keep_o = CNT_W'(i);
        hit    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/phq_commit_ctl.sv
// Commit qualification against the committed-window head pointer.
module phq_commit_ctl
  import phq_pkg::*;
#(
  parameter int PATH_LEN = 3,
  parameter int SEQ_W    = 16,
  parameter int CNT_W    = 5,
  parameter int HP_W     = 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [HP_W-1:0]  hptr_i,
  input  logic [SEQ_W-1:0] head_seq_i,
  input  logic             cmt_valid_i,
  input  logic [SEQ_W-1:0] cmt_seq_i,
  output cmt_act_e         act_o
);

  logic qualify;

  assign qualify = cmt_valid_i && (cnt_i != '0) &&
                   (32'(hptr_i) < 32'(cnt_i)) && (head_seq_i <= cmt_seq_i);

  always_comb begin
    act_o = CMT_HOLD;
    if (qualify) act_o = (32'(hptr_i) >= PATH_LEN) ? CMT_POP : CMT_ADV;
  end

endmodule

// File: rtl/phq_hist_tap.sv
// Newest-first target read-out for index hashing.
module phq_hist_tap #(
  parameter  int DEPTH    = 16,
  parameter  int ADDR_W   = 32,
  parameter  int PATH_LEN = 3,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic [PTR_W-1:0]              head_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  tgt_i,
  output logic [PATH_LEN*ADDR_W-1:0]    hist_tgt_o,
  output logic [PATH_LEN-1:0]           hist_vld_o
);

  for (genvar p = 0; p < PATH_LEN; p++) begin : g_tap
    logic [PTR_W-1:0] idx;
    assign idx           = head_i + PTR_W'(cnt_i) - PTR_W'(p + 1);
    assign hist_vld_o[p] = 32'(cnt_i) > 32'(p);
    assign hist_tgt_o[p*ADDR_W +: ADDR_W] = hist_vld_o[p] ? tgt_i[idx] : '0;
  end

endmodule

// File: rtl/phq_path_queue.sv
// DEPTH must be a power of two, at least 2.
module phq_path_queue
  import phq_pkg::*;
#(
  parameter  int ADDR_W   = 32,
  parameter  int SEQ_W    = 16,
  parameter  int DEPTH    = 16,
  parameter  int PATH_LEN = 3,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int HP_W     = $clog2(PATH_LEN + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rec_valid_i,
  input  logic [ADDR_W-1:0]          rec_pc_i,
  input  logic [ADDR_W-1:0]          rec_tgt_i,
  input  logic [SEQ_W-1:0]           rec_seq_i,
  input  logic                       cmt_valid_i,
  input  logic [SEQ_W-1:0]           cmt_seq_i,
  input  logic                       sq_valid_i,
  input  logic [SEQ_W-1:0]           sq_seq_i,
  input  logic                       fix_valid_i,
  input  logic [ADDR_W-1:0]          fix_tgt_i,
  output logic [CNT_W-1:0]           count_o,
  output logic                       full_o,
  output logic [HP_W-1:0]            hptr_o,
  output logic [ADDR_W-1:0]          oldest_pc_o,
  output logic [SEQ_W-1:0]           oldest_seq_o,
  output logic [PATH_LEN*ADDR_W-1:0] hist_tgt_o,
  output logic [PATH_LEN-1:0]        hist_vld_o
);

  logic [DEPTH-1:0][ADDR_W-1:0] pc_q, tgt_q;
  logic [DEPTH-1:0][SEQ_W-1:0]  seq_q;
  logic [PTR_W-1:0]             head_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [HP_W-1:0]              hptr_q;

  logic [CNT_W-1:0] cnt_sq, cnt_cm, cnt_n;
  logic [PTR_W-1:0] head_cm, fix_idx, rec_idx;
  logic [HP_W-1:0]  hptr_n;
  logic [SEQ_W-1:0] head_seq;
  logic             pop, adv, fix_go, rec_go;
  cmt_act_e         act;

  // squash first
  phq_squash_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) i_scan (
    .head_i    (head_q),
    .cnt_i     (cnt_q),
    .seq_i     (seq_q),
    .sq_valid_i(sq_valid_i),
    .sq_seq_i  (sq_seq_i),
    .keep_o    (cnt_sq)
  );

  assign head_seq = seq_q[head_q + PTR_W'(hptr_q)];

  // commit sees the post-squash queue
  phq_commit_ctl #(
    .PATH_LEN(PATH_LEN), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .HP_W(HP_W)
  ) i_cmt (
    .cnt_i      (cnt_sq),
    .hptr_i     (hptr_q),
    .head_seq_i (head_seq),
    .cmt_valid_i(cmt_valid_i),
    .cmt_seq_i  (cmt_seq_i),
    .act_o      (act)
  );

  assign pop     = (act == CMT_POP);
  assign adv     = (act == CMT_ADV);
  assign head_cm = head_q + PTR_W'(pop);
  assign cnt_cm  = cnt_sq - CNT_W'(pop);
  assign hptr_n  = hptr_q + HP_W'(adv);

  assign fix_go  = fix_valid_i && (cnt_cm != '0);
  assign fix_idx = head_cm + PTR_W'(cnt_cm) - PTR_W'(1);
  assign rec_go  = rec_valid_i && !full_o;
  assign rec_idx = head_cm + PTR_W'(cnt_cm);
  assign cnt_n   = cnt_cm + CNT_W'(rec_go);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
      hptr_q <= '0;
      pc_q   <= '0;
      tgt_q  <= '0;
      seq_q  <= '0;
    end else begin
      head_q <= head_cm;
      cnt_q  <= cnt_n;
      hptr_q <= hptr_n;
      if (fix_go) tgt_q[fix_idx] <= fix_tgt_i;
      if (rec_go) begin
        pc_q[rec_idx]  <= rec_pc_i;
        tgt_q[rec_idx] <= rec_tgt_i;
        seq_q[rec_idx] <= rec_seq_i;
      end
    end
  end

  phq_hist_tap #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PATH_LEN(PATH_LEN)) i_tap (
    .head_i    (head_q),
    .cnt_i     (cnt_q),
    .tgt_i     (tgt_q),
    .hist_tgt_o(hist_tgt_o),
    .hist_vld_o(hist_vld_o)
  );

  assign count_o      = cnt_q;
  assign full_o       = (32'(cnt_q) == DEPTH);
  assign hptr_o       = hptr_q;
  assign oldest_pc_o  = pc_q[head_q];
  assign oldest_seq_o = seq_q[head_q];

endmodule

// File: rtl/phq_checker.sv
module phq_checker #(
  parameter int DEPTH    = 16,
  parameter int PATH_LEN = 3,
  parameter int CNT_W    = 5,
  parameter int HP_W     = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                rec_valid_i,
  input logic                cmt_valid_i,
  input logic                sq_valid_i,
  input logic                full_o,
  input logic [CNT_W-1:0]    count_o,
  input logic [HP_W-1:0]     hptr_o,
  input logic [PATH_LEN-1:0] hist_vld_o
);

  // R1
  record_grows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i && !full_o && !sq_valid_i && !cmt_valid_i)
    |=> (32'(count_o) == 32'($past(count_o)) + 1));

  // R2
  full_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && rec_valid_i && !sq_valid_i && !cmt_valid_i)
    |=> ($stable(count_o) && full_o && $stable(hptr_o)));

  // R3
  empty_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !rec_valid_i) |=> (count_o == '0 && $stable(hptr_o)));

  // R4
  commit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_valid_i && !sq_valid_i && !rec_valid_i)
    |=> (32'(count_o) + 1 >= 32'($past(count_o)) && count_o <= $past(count_o)));

  // R5
  hptr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(hptr_o) <= PATH_LEN);

  // R6
  squash_shrinks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_valid_i && !rec_valid_i && !cmt_valid_i)
    |=> (count_o <= $past(count_o) && $stable(hptr_o)));

  // R8
  hist_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hist_vld_o) == ((32'(count_o) < PATH_LEN) ? 32'(count_o) : PATH_LEN));

endmodule

bind phq_path_queue phq_checker #(
  .DEPTH(DEPTH), .PATH_LEN(PATH_LEN), .CNT_W(CNT_W), .HP_W(HP_W)
) i_phq_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rec_valid_i(rec_valid_i),
  .cmt_valid_i(cmt_valid_i),
  .sq_valid_i (sq_valid_i),
  .full_o     (full_o),
  .count_o    (count_o),
  .hptr_o     (hptr_o),
  .hist_vld_o (hist_vld_o)
);

// File: tb/test_phq_path_queue.sv
module test_phq_path_queue;

  localparam int AW = 8, SW = 8, DEPTH = 4, PL = 2;
  localparam int CW = $clog2(DEPTH + 1), HW = $clog2(PL + 1);

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic          rst_ni;
  logic          rec_valid_i, cmt_valid_i, sq_valid_i, fix_valid_i;
  logic [AW-1:0] rec_pc_i, rec_tgt_i, fix_tgt_i;
  logic [SW-1:0] rec_seq_i, cmt_seq_i, sq_seq_i;
  logic [CW-1:0] count_o;
  logic          full_o;
  logic [HW-1:0] hptr_o;
  logic [AW-1:0] oldest_pc_o;
  logic [SW-1:0] oldest_seq_o;
  logic [PL*AW-1:0] hist_tgt_o;
  logic [PL-1:0] hist_vld_o;

  phq_path_queue #(.ADDR_W(AW), .SEQ_W(SW), .DEPTH(DEPTH), .PATH_LEN(PL)) i_phq_path_queue (
    .clk_i, .rst_ni, .rec_valid_i, .rec_pc_i, .rec_tgt_i, .rec_seq_i,
    .cmt_valid_i, .cmt_seq_i, .sq_valid_i, .sq_seq_i, .fix_valid_i, .fix_tgt_i,
    .count_o, .full_o, .hptr_o, .oldest_pc_o, .oldest_seq_o, .hist_tgt_o, .hist_vld_o
  );

  int vectors = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_pc [DEPTH];
  logic [AW-1:0] m_tgt[DEPTH];
  logic [SW-1:0] m_seq[DEPTH];
  int m_cnt = 0, m_hp = 0;

  always @(posedge clk_i) begin
    cyc = cyc + 1;
    if (cyc > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL R9 watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "count", int'(count_o), m_cnt);
    chk(tag, "full", int'(full_o), int'(m_cnt == DEPTH));
    chk(tag, "hptr", int'(hptr_o), m_hp);
    for (int p = 0; p < PL; p++) begin
      chk(tag, "hist_vld", int'(hist_vld_o[p]), int'(p < m_cnt));
      chk(tag, "hist_tgt", int'(hist_tgt_o[p*AW +: AW]),
          (p < m_cnt) ? int'(m_tgt[m_cnt-1-p]) : 0);
    end
    if (m_cnt > 0) begin
      chk(tag, "oldest_pc", int'(oldest_pc_o), int'(m_pc[0]));
      chk(tag, "oldest_seq", int'(oldest_seq_o), int'(m_seq[0]));
    end
  endtask

  task automatic model_step(input bit rc, input logic [AW-1:0] rpc, rtgt, input logic [SW-1:0] rseq,
                            input bit cm, input logic [SW-1:0] cs, input bit sq, input logic [SW-1:0] ss,
                            input bit fx, input logic [AW-1:0] ft);
    bit full_pre;
    full_pre = (m_cnt == DEPTH);
    if (sq) begin
      for (int i = 0; i < m_cnt; i++) begin
        if (m_seq[i] > ss) begin
          m_cnt = i;
          break;
        end
      end
    end
    if (cm && m_cnt > 0 && m_hp < m_cnt && m_seq[m_hp] <= cs) begin
      if (m_hp >= PL) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          m_pc[i] = m_pc[i+1]; m_tgt[i] = m_tgt[i+1]; m_seq[i] = m_seq[i+1];
        end
        m_cnt--;
      end else m_hp++;
    end
    if (fx && m_cnt > 0) m_tgt[m_cnt-1] = ft;
    if (rc && !full_pre) begin
      m_pc[m_cnt] = rpc; m_tgt[m_cnt] = rtgt; m_seq[m_cnt] = rseq;
      m_cnt++;
    end
  endtask

  task automatic apply(input string tag, input bit rc, input logic [AW-1:0] rpc, rtgt,
                       input logic [SW-1:0] rseq, input bit cm, input logic [SW-1:0] cs,
                       input bit sq, input logic [SW-1:0] ss, input bit fx, input logic [AW-1:0] ft);
    rec_valid_i = rc; rec_pc_i = rpc; rec_tgt_i = rtgt; rec_seq_i = rseq;
    cmt_valid_i = cm; cmt_seq_i = cs; sq_valid_i = sq; sq_seq_i = ss;
    fix_valid_i = fx; fix_tgt_i = ft;
    model_step(rc, rpc, rtgt, rseq, cm, cs, sq, ss, fx, ft);
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    rec_valid_i = 0; cmt_valid_i = 0; sq_valid_i = 0; fix_valid_i = 0;
    rec_pc_i = '0; rec_tgt_i = '0; rec_seq_i = '0; cmt_seq_i = '0; sq_seq_i = '0; fix_tgt_i = '0;
    m_cnt = 0; m_hp = 0;
    repeat (2) @(negedge clk_i);
    compare_all("R10");
    rst_ni = 1'b1;
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] step_lfsr(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    do_reset();

    // R1: append three
    apply("R1", 1, 8'h11, 8'hA1, 8'd10, 0, 0, 0, 0, 0, 0);
    apply("R1", 1, 8'h22, 8'hA2, 8'd20, 0, 0, 0, 0, 0, 0);
    apply("R1", 1, 8'h33, 8'hA3, 8'd30, 0, 0, 0, 0, 0, 0);
    chk("R1", "count_direct", int'(count_o), 3);
    chk("R8", "slot1_direct", int'(hist_tgt_o[AW +: AW]), 8'hA2);

    // R7: fix youngest
    apply("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'hF3);
    chk("R7", "slot0_direct", int'(hist_tgt_o[0 +: AW]), 8'hF3);

    // R4: blocked then advancing
    apply("R4", 0, 0, 0, 0, 1, 8'd5, 0, 0, 0, 0);
    chk("R4", "hptr_direct", int'(hptr_o), 0);
    apply("R4", 0, 0, 0, 0, 1, 8'd10, 0, 0, 0, 0);
    apply("R5", 0, 0, 0, 0, 1, 8'd20, 0, 0, 0, 0);
    chk("R5", "hptr_direct", int'(hptr_o), 2);
    apply("R5", 0, 0, 0, 0, 1, 8'd30, 0, 0, 0, 0);
    chk("R5", "count_pop", int'(count_o), 2);
    chk("R5", "oldest_direct", int'(oldest_pc_o), 8'h22);

    // R6: partial squash
    apply("R6", 0, 0, 0, 0, 0, 0, 1, 8'd25, 0, 0);
    chk("R6", "count_direct", int'(count_o), 1);
    apply("R4", 0, 0, 0, 0, 1, 8'd100, 0, 0, 0, 0);
    chk("R4", "hptr_beyond_count", int'(count_o), 1);

    // R3: empty then commit and fix
    apply("R6", 0, 0, 0, 0, 0, 0, 1, 8'd0, 0, 0);
    apply("R3", 0, 0, 0, 0, 1, 8'd200, 0, 0, 0, 0);
    apply("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h55);
    chk("R3", "count_direct", int'(count_o), 0);

    // R2: fill and overfill
    for (int k = 0; k < DEPTH; k++)
      apply("R2", 1, AW'(8'h40 + k), AW'(8'hB0 + k), SW'(40 + 10 * k), 0, 0, 0, 0, 0, 0);
    chk("R2", "full_direct", int'(full_o), 1);
    apply("R2", 1, 8'h99, 8'h99, 8'd99, 0, 0, 0, 0, 0, 0);
    chk("R2", "slot0_unchanged", int'(hist_tgt_o[0 +: AW]), 8'hB3);

    // R9: ordering within a cycle
    do_reset();
    apply("R9", 1, 8'h01, 8'hC1, 8'd1, 0, 0, 0, 0, 0, 0);
    apply("R9", 1, 8'h02, 8'hC2, 8'd2, 0, 0, 0, 0, 0, 0);
    apply("R9", 1, 8'h03, 8'hC3, 8'd3, 0, 0, 0, 0, 0, 0);
    apply("R9", 1, 8'h09, 8'h99, 8'd9, 1, 8'd2, 1, 8'd2, 1, 8'hEE);
    chk("R9", "slot1_fixed", int'(hist_tgt_o[AW +: AW]), 8'hEE);
    chk("R9", "hptr_direct", int'(hptr_o), 1);
    chk("R9", "count_direct", int'(count_o), 3);

    // random mix
    begin
      logic [SW-1:0] nseq;
      nseq = 8'd10;
      for (int n = 0; n < 4000; n++) begin
        bit rc, cm, sq, fx;
        logic [SW-1:0] rs;
        lfsr = step_lfsr(lfsr);
        rc = lfsr[2:0] != 3'd0;
        cm = lfsr[4:3] != 2'd0;
        sq = lfsr[8:5] == 4'd0;
        fx = lfsr[10:9] == 2'd0;
        rs = nseq;
        if (rc) nseq = nseq + SW'(lfsr[12:11]) + 1'b1;
        apply("R9", rc, lfsr[20:13], lfsr[28:21], rs,
              cm, nseq - SW'(lfsr[15:13]), sq, nseq - SW'(lfsr[18:16]), fx, lfsr[31:24]);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule